// File: doc/BRIEF.md
# Stream End-of-Packet Marker Embedder

This block takes a valid/ready word stream that carries a sideband end-of-packet flag and produces a stream without that flag. The flag moves into the data itself. A word that closes a packet goes out as a group of three words: a fixed escape word, then a control word whose low 32 bits equal 1, then the payload word. Any payload word that happens to equal the escape word goes out in the same three-word group. In that case the control word is all zeros, which marks a literal. All other words pass through as a single output word. The receiver recovers the flag with the inverse rules. The word after an escape is a control word, of which only the low 32 bits matter, and the word after a control word is always payload.

Upstream is stalled while the escape and control words are produced. The input word is held on the input port and is taken only in the cycle its own payload word is written into the output stage. Back-pressure follows the usual rules. A word moves on an edge where valid and ready are both high. A source keeps valid, data and last stable until the word is taken. Once output valid is high, the block keeps the output word stable until it is taken. Output valid and output data come from registers in a two-entry stage. Input ready depends on the stage occupancy, the group phase and the presented input word. It never depends on output ready. A synchronous reset or clear empties the stage and drops any partly sent group.

Top module: `eop_embedder`

## Requirements
- R1: An input word whose last flag is 0 and whose value differs from the escape word 0xDEADBEEFFEEDCAFE leaves as exactly one output word with the same value.
- R2: An input word with last flag 1 leaves as three words in order: 0xDEADBEEFFEEDCAFE, the control word 0x0000000000000001, then the input value.
- R3: An input word with last flag 0 whose value equals 0xDEADBEEFFEEDCAFE leaves as three words: the escape word, the control word 0x0000000000000000, then the escape word again as payload.
- R4: A last-flagged input word equal to the escape word is sent once, as escape, control 1, escape, with no second escaping of the payload.
- R5: For a word that needs a group, with output ready held high, input ready is low for the two cycles in which the escape and control words are produced, and the word is accepted in the third cycle.
- R6: With output ready held high, unescaped input words are accepted on every cycle, one word per clock.
- R7: While output valid is high and output ready is low, output valid stays high and output data does not change on the next cycle.
- R8: From an empty state, a word accepted on a clock edge is shown on the output (valid high, same data) right after that edge.
- R9: Input ready does not change when output ready changes within a cycle.
- R10: The output stage holds two words: with output ready low, two unescaped words are accepted and input ready then goes low.
- R11: A clear empties the output (valid low on the next cycle) and drops a partly sent group, so the next plain word leaves as a single word.
- R12: After reset, output valid is low and input ready is high for a plain presented word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear, active high; same effect as reset |
| in_data | input | 64 | Input payload word |
| in_valid | input | 1 | Input word present |
| in_last | input | 1 | Input word ends a packet |
| in_ready | output | 1 | Block accepts the input word on this edge |
| out_data | output | 64 | Output word (escape, control or payload) |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word on this edge |

## Verification
A sequencer stuck in the wrong phase shows at the ports within one or two output transfers. Escape and control words then appear in the wrong place, or a payload word is missing or repeated, and a decode of the output no longer matches the input words and flags. A wrong occupancy count in the output stage shows on the next pop as a lost or duplicated word. It can also show as input ready staying high while the stage is full. A control word built with the wrong polarity flips the recovered last flag of the very next decoded word.

// File: rtl/eop_embed_pkg.sv
package eop_embed_pkg;

  // Phase of the three-word group sequencer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // pass-through, next word may start a group
    PH_CTRL = 2'd1,  // escape already pushed, control word is next
    PH_DATA = 2'd2   // control already pushed, payload is next
  } phase_e;

endpackage

// File: rtl/eop_esc_match.sv
module eop_esc_match #(
  parameter int                DATA_W  = 64,
  parameter int                LANE_W  = 16,
  parameter logic [DATA_W-1:0] PATTERN = 64'hDEADBEEFFEEDCAFE
) (
  input  logic [DATA_W-1:0] word,
  output logic              hit
);
  localparam int NLANE = DATA_W / LANE_W;

  logic [NLANE-1:0] lane_eq;

  // Equality split into lanes so the reduction tree stays shallow
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign lane_eq[l] = (word[l*LANE_W +: LANE_W] == PATTERN[l*LANE_W +: LANE_W]);
  end

  assign hit = &lane_eq;

  initial begin
    if (DATA_W % LANE_W != 0) $error("DATA_W must be a multiple of LANE_W");
  end
endmodule

// File: rtl/eop_group_seq.sv
module eop_group_seq
  import eop_embed_pkg::*;
#(
  parameter int                DATA_W   = 64,
  parameter int                CTRL_W   = 32,
  parameter int                LANE_W   = 16,
  parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE,
  parameter logic [CTRL_W-1:0] EOP_CODE = 1,
  parameter logic [CTRL_W-1:0] LIT_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              slot_free,
  output logic              push,
  output logic [DATA_W-1:0] push_data
);
  localparam logic [DATA_W-1:0] EOP_WORD = DATA_W'(EOP_CODE);
  localparam logic [DATA_W-1:0] LIT_WORD = DATA_W'(LIT_CODE);

  phase_e ph_q, ph_d;
  logic   eop_q, eop_d;
  logic   esc_hit;
  logic   needs_group;

  eop_esc_match #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .PATTERN(ESC_WORD)
  ) u_match (
    .word(in_data),
    .hit (esc_hit)
  );

  assign needs_group = in_last | esc_hit;

  // Ready never looks at downstream ready, only at the registered slot state
  assign in_ready = slot_free &&
                    (((ph_q == PH_IDLE) && !needs_group) || (ph_q == PH_DATA));

  always_comb begin
    ph_d      = ph_q;
    eop_d     = eop_q;
    push      = 1'b0;
    push_data = in_data;
    unique case (ph_q)
      PH_IDLE: begin
        if (in_valid && slot_free) begin
          push = 1'b1;
          if (needs_group) begin
            push_data = ESC_WORD;
            eop_d     = in_last;
            ph_d      = PH_CTRL;
          end
        end
      end
      PH_CTRL: begin
        if (slot_free) begin
          push      = 1'b1;
          push_data = eop_q ? EOP_WORD : LIT_WORD;
          ph_d      = PH_DATA;
        end
      end
      PH_DATA: begin
        if (in_valid && slot_free) begin
          push = 1'b1;
          ph_d = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph_q  <= PH_IDLE;
      eop_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      eop_q <= eop_d;
    end
  end

  // R2
  esc_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE && push && needs_group && !clr) |=> (ph_q == PH_CTRL));

  // R5
  ctrl_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_CTRL && push && !clr) |=> (ph_q == PH_DATA));

  // R5
  data_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA && in_valid && in_ready && !clr) |=> (ph_q == PH_IDLE));

  // R11
  clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/eop_out_stage.sv
module eop_out_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              slot_free,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam logic [1:0] CNT_EMPTY = 2'd0;
  localparam logic [1:0] CNT_ONE   = 2'd1;
  localparam logic [1:0] CNT_TWO   = 2'd2;

  logic [1:0]        cnt_q;
  logic [DATA_W-1:0] head_q, tail_q;
  logic              pop;

  assign slot_free = (cnt_q != CNT_TWO);
  assign out_valid = (cnt_q != CNT_EMPTY);
  assign out_data  = head_q;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= CNT_EMPTY;
    end else begin
      unique case (cnt_q)
        CNT_EMPTY: if (push) cnt_q <= CNT_ONE;
        CNT_ONE: begin
          if (push && !pop)      cnt_q <= CNT_TWO;
          else if (!push && pop) cnt_q <= CNT_EMPTY;
        end
        CNT_TWO: if (pop) cnt_q <= CNT_ONE;
        default: cnt_q <= CNT_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((cnt_q == CNT_EMPTY && push) || (cnt_q == CNT_ONE && push && pop))
      head_q <= push_data;
    else if (cnt_q == CNT_TWO && pop)
      head_q <= tail_q;
    if (cnt_q == CNT_ONE && push && !pop)
      tail_q <= push_data;
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

  // R10
  fill_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_ONE && push && !pop && !clr) |=> !slot_free);

  // R11
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !out_valid);
endmodule

// File: rtl/eop_embedder.sv
module eop_embedder #(
  parameter int                DATA_W   = 64,
  parameter int                CTRL_W   = 32,
  parameter int                LANE_W   = 16,
  parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE,
  parameter logic [CTRL_W-1:0] EOP_CODE = 1,
  parameter logic [CTRL_W-1:0] LIT_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  logic              slot_free;
  logic              push;
  logic [DATA_W-1:0] push_data;

  eop_group_seq #(
    .DATA_W  (DATA_W),
    .CTRL_W  (CTRL_W),
    .LANE_W  (LANE_W),
    .ESC_WORD(ESC_WORD),
    .EOP_CODE(EOP_CODE),
    .LIT_CODE(LIT_CODE)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .slot_free(slot_free),
    .push     (push),
    .push_data(push_data)
  );

  eop_out_stage #(
    .DATA_W(DATA_W)
  ) u_stage (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .push     (push),
    .push_data(push_data),
    .slot_free(slot_free),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready)
  );

  // R6
  push_room_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> slot_free);

  initial begin
    if (CTRL_W > DATA_W) $error("CTRL_W must not exceed DATA_W");
  end
endmodule

// File: tb/eop_embedder_bench.sv
`timescale 1ns/1ps
module eop_embedder_bench;
  localparam logic [63:0] ESC = 64'hDEADBEEFFEEDCAFE;
  localparam int NV = 16;
  // {last, data}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 64'h0000_0000_0000_0011},          // R1
    {1'b0, 64'h1234_5678_9ABC_DEF0},          // R1
    {1'b1, 64'hAAAA_BBBB_CCCC_DDDD},          // R2
    {1'b0, ESC},                              // R3
    {1'b0, ESC},                              // R3 back to back
    {1'b1, ESC},                              // R4
    {1'b0, 64'h0000_0000_0000_0001},          // R1 looks like control
    {1'b0, 64'h0000_0000_0000_0000},          // R1
    {1'b1, 64'h0000_0000_0000_0001},          // R2
    {1'b1, 64'h0000_0000_0000_0000},          // R2 back to back last
    {1'b0, 64'hDEADBEEF_FEEDCAFF},            // R1 near miss
    {1'b0, 64'hDEADBEEE_FEEDCAFE},            // R1 near miss
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF},          // R2
    {1'b0, ESC},                              // R3
    {1'b1, ESC},                              // R4
    {1'b0, 64'h5555_AAAA_5555_AAAA}           // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        out_ready = 1'b0;
  wire         in_ready;
  wire  [63:0] out_data;
  wire         out_valid;

  int total = 0;
  int bad = 0;
  logic [31:0] lf = 32'h1ACE_5EED;

  eop_embedder u_eop_embedder (
    .clk(clk), .rst(rst), .clr(clr),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  // Expected encoded stream, computed from R1..R4 rules
  logic [63:0] exp_w [64];
  string       exp_r [64];
  int          exp_n = 0;

  // Decoder state
  int          dec_ph = 0;
  logic        dec_last = 1'b0;
  int          di = 0;

  task automatic decode(input logic [63:0] w);
    if (dec_ph == 0) begin
      if (w == ESC) dec_ph = 1;
      else begin
        chk(di < NV && VEC[di] == {1'b0, w}, "R1 decode", w, VEC[di][63:0]);
        di++;
      end
    end else if (dec_ph == 1) begin
      dec_last = (w[31:0] == 32'd1);
      dec_ph = 2;
    end else begin
      chk(di < NV && VEC[di] == {dec_last, w}, "R2 decode", {63'd0, dec_last}, {63'd0, VEC[di][64]});
      di++;
      dec_ph = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // build expected stream
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][64] || VEC[i][63:0] == ESC) begin
        exp_w[exp_n] = ESC; exp_r[exp_n] = VEC[i][64] ? "R2 escape" : "R3 escape"; exp_n++;
        exp_w[exp_n] = VEC[i][64] ? 64'd1 : 64'd0;
        exp_r[exp_n] = VEC[i][64] ? (VEC[i][63:0] == ESC ? "R4 control" : "R2 control") : "R3 control";
        exp_n++;
        exp_w[exp_n] = VEC[i][63:0]; exp_r[exp_n] = (VEC[i][64] && VEC[i][63:0] == ESC) ? "R4 payload" : "R2 payload"; exp_n++;
      end else begin
        exp_w[exp_n] = VEC[i][63:0]; exp_r[exp_n] = "R1 plain"; exp_n++;
      end
    end

    // R12 reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R12 out_valid", {63'd0, out_valid}, 64'd0);
    chk(in_ready == 1'b1, "R12 in_ready", {63'd0, in_ready}, 64'd1);

    // Table walk with random stalls, raw and decoded comparison
    begin
      int vi = 0;
      int oi = 0;
      bit pend = 0;
      bit held = 0;
      logic [63:0] held_w = '0;
      for (int cyc = 0; cyc < 4000 && (vi < NV || oi < exp_n); cyc++) begin
        @(negedge clk);
        if (held) begin
          chk(out_valid && out_data == held_w, "R7 hold", out_data, held_w);
        end
        if (!pend) begin
          if (vi < NV && rnd() % 4 != 0) begin
            pend = 1;
            in_valid = 1'b1;
            {in_last, in_data} = VEC[vi];
          end else begin
            in_valid = 1'b0;
            in_last = 1'b0;
            in_data = '0;
          end
        end
        out_ready = (rnd() % 3 != 0);
        #1;
        if (in_valid && in_ready) begin
          vi++;
          pend = 0;
        end
        held = out_valid && !out_ready;
        held_w = out_data;
        if (out_valid && out_ready) begin
          chk(oi < exp_n && out_data == exp_w[oi], exp_r[oi], out_data, exp_w[oi]);
          decode(out_data);
          oi++;
        end
      end
      chk(oi == exp_n, "R1 word count", 64'(oi), 64'(exp_n));
      chk(di == NV, "R2 decoded count", 64'(di), 64'(NV));
    end
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    out_ready = 1'b1;
    repeat (4) idle_cycle();

    // R8 latency, R10 depth, R9 no ready feed-through
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 64'h0A0A; in_last = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R8 accept", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && out_data == 64'h0A0A, "R8 latency", out_data, 64'h0A0A);
    in_data = 64'h0B0B;
    chk(in_ready == 1'b1, "R10 second slot", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0; in_data = '0;
    #1;
    chk(in_ready == 1'b0, "R10 full", {63'd0, in_ready}, 64'd0);
    chk(out_data == 64'h0A0A, "R7 head kept", out_data, 64'h0A0A);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R9 no feed-through", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    #1;
    chk(out_valid && out_data == 64'h0B0B, "R10 second word", out_data, 64'h0B0B);
    chk(in_ready == 1'b1, "R10 room again", {63'd0, in_ready}, 64'd1);
    repeat (3) idle_cycle();

    // R5 stall of two cycles for a grouped word
    begin
      int lows = 0;
      logic [63:0] seen [3];
      int ns = 0;
      @(negedge clk);
      out_ready = 1'b1;
      in_valid = 1'b1; in_last = 1'b1; in_data = 64'hC0FFEE;
      for (int k = 0; k < 6; k++) begin
        #1;
        if (out_valid && ns < 3) begin seen[ns] = out_data; ns++; end
        if (in_ready) break;
        lows++;
        @(negedge clk);
      end
      chk(lows == 2, "R5 stall cycles", 64'(lows), 64'd2);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_data = '0;
      #1;
      if (out_valid && ns < 3) begin seen[ns] = out_data; ns++; end
      chk(ns == 3 && seen[0] == ESC && seen[1] == 64'd1 && seen[2] == 64'hC0FFEE,
          "R2 group order", seen[2], 64'hC0FFEE);
    end
    repeat (3) idle_cycle();

    // R6 one word per clock
    begin
      int acc = 0;
      int outs = 0;
      @(negedge clk);
      out_ready = 1'b1;
      for (int k = 0; k < 8; k++) begin
        if (k > 0) @(negedge clk);
        in_valid = 1'b1; in_last = 1'b0; in_data = 64'h100 + 64'(k);
        #1;
        if (in_ready) acc++;
        if (out_valid) outs++;
      end
      chk(acc == 8, "R6 accepts", 64'(acc), 64'd8);
      chk(outs == 7, "R6 outputs", 64'(outs), 64'd7);
      @(negedge clk);
      in_valid = 1'b0; in_data = '0;
    end
    repeat (3) idle_cycle();

    // R11 clear mid-group
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_last = 1'b1; in_data = 64'h7777;
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    @(negedge clk);
    clr = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R11 emptied", {63'd0, out_valid}, 64'd0);
    chk(in_ready == 1'b1, "R11 idle", {63'd0, in_ready}, 64'd1);
    in_valid = 1'b1; in_data = 64'h8888;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0;
    out_ready = 1'b1;
    #1;
    chk(out_valid && out_data == 64'h8888, "R11 plain after clear", out_data, 64'h8888);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11 single word", {63'd0, out_valid}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule